// File: doc/BRIEF.md
# Option ROM header version reader

This block pulls the version number out of an expansion ROM image. The ROM is reached through a simple byte-wide read port with a fixed latency. After a one-cycle start pulse, the block does two things before it reads any version data:

- It confirms the two-byte header signature.
- It follows an 8-bit pointer stored in the header to a data structure, and confirms that structure's four-letter tag.

Only when both signatures match does it read the minor and major version bytes from that structure.

The block reads one byte at a time and never has more than one read in flight. It stops at the first byte that does not match. When it finishes, it raises `done` for one cycle. At that moment `err` is valid, together with the two version bytes. The results stay on the outputs until the next accepted start. A host typically fires `start` once after reset and copies the version when `done` arrives with `err` low.

Top module: `romhdr_version_reader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the outputs `busy`, `done`, `err`, `ver_major`, `ver_minor` and `rom_req` are all 0.
- R2: `rom_req` is high for exactly one cycle per byte, with `rom_addr` valid in that cycle. The block takes `rom_rdata` in the cycle that comes RD_LAT cycles after the request cycle. It issues no new request until that byte has been taken, so at least RD_LAT+1 cycles separate two requests.
- R3: The byte at address 0 must equal 0x55 and the byte at address 1 must equal 0xAA. Any other value ends the run with `err`=1.
- R4: The byte at address 0x18 is the structure pointer, taken as an unsigned 8-bit value. Every structure address is the pointer plus an offset, carried into bit 8 with no wrap (for example, pointer 0xFF with offset 0x13 gives address 0x112).
- R5: The bytes at pointer+0, +1, +2 and +3 must be 0x50, 0x43, 0x49 and 0x52 ('P', 'C', 'I', 'R'). Any mismatch ends the run with `err`=1.
- R6: On success the block makes nine reads, in the order 0, 1, 0x18, pointer+0 to pointer+3, pointer+0x12, pointer+0x13. It reports `ver_minor` as the byte at pointer+0x12 and `ver_major` as the byte at pointer+0x13, with `err`=0.
- R7: `done` is a single-cycle pulse, once per accepted start. When `err` is 1, `ver_major` and `ver_minor` are both 0.
- R8: The run stops at the first mismatching byte. No read follows it, so the number of reads equals the position of the failing byte in the R6 order, counting from 1.
- R9: A start while `busy` is 1 is ignored and the run in progress completes unchanged. An accepted start clears `err` and both version bytes to 0 in the following cycle. From the `done` pulse until the next accepted start, those three outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a header scan |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when the scan ends |
| err | output | 1 | Scan failed a signature check (valid from `done`) |
| ver_major | output | 8 | Major version byte, 0 on error |
| ver_minor | output | 8 | Minor version byte, 0 on error |
| rom_req | output | 1 | Read request, one cycle per byte |
| rom_addr | output | ADDR_W | Byte address, valid with `rom_req` |
| rom_rdata | input | 8 | Read data, valid RD_LAT cycles after the request |

## Verification
The ROM model drives a junk byte on every cycle except the one where the data is due. A design that samples one cycle early or late therefore reads junk and fails a signature.

Each signature byte is corrupted in its own run. The bench then checks that the error flag is set, that the versions read zero, and that the read count stops exactly at the bad byte. A design that kept scanning, or that reported stale version bytes, would show up here.

A pointer of 0xFF puts the version bytes above address 0xFF. A design that wrapped the sum to 8 bits would read from the wrong addresses.

Finally, the bench fires a second start in the middle of a scan and watches the outputs between runs. This exposes a design that restarts while busy, or one whose results drift after `done`.

// File: rtl/romhdr_pkg.sv
package romhdr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFS_W  = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT
  } ctl_state_e;

  // Scan order; the sequence itself is behaviour (first mismatch stops it).
  typedef enum logic [3:0] {
    STEP_SIG0,
    STEP_SIG1,
    STEP_PTR,
    STEP_TAG0,
    STEP_TAG1,
    STEP_TAG2,
    STEP_TAG3,
    STEP_MINOR,
    STEP_MAJOR
  } step_e;

  typedef struct packed {
    logic [OFS_W-1:0]  offset;
    logic              use_ptr;
    logic              check;
    logic [BYTE_W-1:0] exp_byte;
    logic              grab_ptr;
    logic              grab_minor;
    logic              is_last;
  } step_info_t;

  localparam logic [BYTE_W-1:0] HDR_SIG_A = 8'h55;
  localparam logic [BYTE_W-1:0] HDR_SIG_B = 8'hAA;
  localparam logic [OFS_W-1:0]  PTR_LOC   = 9'h018;
  localparam logic [OFS_W-1:0]  MINOR_OFS = 9'h012;
  localparam logic [OFS_W-1:0]  MAJOR_OFS = 9'h013;
  localparam logic [BYTE_W-1:0] TAG_CH0   = 8'h50;
  localparam logic [BYTE_W-1:0] TAG_CH1   = 8'h43;
  localparam logic [BYTE_W-1:0] TAG_CH2   = 8'h49;
  localparam logic [BYTE_W-1:0] TAG_CH3   = 8'h52;

endpackage

// File: rtl/romhdr_step_decode.sv
module romhdr_step_decode
  import romhdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  step_e                    step,
  input  logic [BYTE_W-1:0]        ptr,
  output step_info_t               info,
  output logic [ADDR_W-1:0]        addr
);

  always_comb begin
    info = '0;
    case (step)
      STEP_SIG0: begin
        info.check    = 1'b1;
        info.exp_byte = HDR_SIG_A;
      end
      STEP_SIG1: begin
        info.offset   = 9'd1;
        info.check    = 1'b1;
        info.exp_byte = HDR_SIG_B;
      end
      STEP_PTR: begin
        info.offset   = PTR_LOC;
        info.grab_ptr = 1'b1;
      end
      STEP_TAG0: begin
        info.use_ptr  = 1'b1;
        info.check    = 1'b1;
        info.exp_byte = TAG_CH0;
      end
      STEP_TAG1: begin
        info.use_ptr  = 1'b1;
        info.offset   = 9'd1;
        info.check    = 1'b1;
        info.exp_byte = TAG_CH1;
      end
      STEP_TAG2: begin
        info.use_ptr  = 1'b1;
        info.offset   = 9'd2;
        info.check    = 1'b1;
        info.exp_byte = TAG_CH2;
      end
      STEP_TAG3: begin
        info.use_ptr  = 1'b1;
        info.offset   = 9'd3;
        info.check    = 1'b1;
        info.exp_byte = TAG_CH3;
      end
      STEP_MINOR: begin
        info.use_ptr    = 1'b1;
        info.offset     = MINOR_OFS;
        info.grab_minor = 1'b1;
      end
      STEP_MAJOR: begin
        info.use_ptr = 1'b1;
        info.offset  = MAJOR_OFS;
        info.is_last = 1'b1;
      end
      default: info = '0;
    endcase
  end

  // Pointer plus offset in full address width: no wrap past 0xFF (R4).
  logic [ADDR_W-1:0] base;
  assign base = info.use_ptr ? ADDR_W'(ptr) : '0;
  assign addr = base + ADDR_W'(info.offset);

endmodule

// File: rtl/romhdr_byte_judge.sv
module romhdr_byte_judge
  import romhdr_pkg::*;
(
  input  step_info_t        info,
  input  logic [BYTE_W-1:0] data,
  output logic              mismatch
);

  assign mismatch = info.check && (data != info.exp_byte);

endmodule

// File: rtl/romhdr_read_agent.sv
module romhdr_read_agent
  import romhdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              rom_req,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_rdata,
  output logic              rd_done,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int unsigned LAT_W = $clog2(RD_LAT + 1);

  logic             waiting;
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_req  <= 1'b0;
      rom_addr <= '0;
      waiting  <= 1'b0;
      cnt      <= '0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rom_req <= 1'b0;
      rd_done <= 1'b0;
      if (go && !waiting) begin
        rom_req  <= 1'b1;
        rom_addr <= go_addr;
        waiting  <= 1'b1;
        cnt      <= LAT_W'(RD_LAT);
      end else if (waiting) begin
        if (cnt == '0) begin
          rd_data <= rom_rdata;
          rd_done <= 1'b1;
          waiting <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2: a request lasts one cycle only.
  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    rom_req |=> !rom_req);

  // R2: the controller never launches while a byte is still in flight.
  p_go_idle_r2: assert property (@(posedge clk) disable iff (rst)
    go |-> !waiting);

  // R2: returned data only follows an outstanding read.
  p_done_follows_wait_r2: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !waiting && !rom_req);

endmodule

// File: rtl/romhdr_version_reader.sv
module romhdr_version_reader
  import romhdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        ver_major,
  output logic [7:0]        ver_minor,
  output logic              rom_req,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_rdata
);

  ctl_state_e        state;
  step_e             step;
  logic [BYTE_W-1:0] ptr_q;
  logic [BYTE_W-1:0] minor_q;
  step_info_t        info;
  logic [ADDR_W-1:0] step_addr;
  logic              go;
  logic              rd_done;
  logic [BYTE_W-1:0] rd_data;
  logic              mismatch;

  assign busy = (state != ST_IDLE);
  assign go   = (state == ST_LAUNCH);

  romhdr_step_decode #(.ADDR_W(ADDR_W)) u_decode (
    .step (step),
    .ptr  (ptr_q),
    .info (info),
    .addr (step_addr)
  );

  romhdr_read_agent #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_agent (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_addr   (step_addr),
    .rom_req   (rom_req),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_rdata),
    .rd_done   (rd_done),
    .rd_data   (rd_data)
  );

  romhdr_byte_judge u_judge (
    .info     (info),
    .data     (rd_data),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= STEP_SIG0;
      ptr_q     <= '0;
      minor_q   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      ver_major <= '0;
      ver_minor <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            step      <= STEP_SIG0;
            err       <= 1'b0;
            ver_major <= '0;
            ver_minor <= '0;
            state     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (rd_done) begin
            if (mismatch) begin
              done      <= 1'b1;
              err       <= 1'b1;
              ver_major <= '0;
              ver_minor <= '0;
              state     <= ST_IDLE;
            end else begin
              if (info.grab_ptr)   ptr_q   <= rd_data;
              if (info.grab_minor) minor_q <= rd_data;
              if (info.is_last) begin
                done      <= 1'b1;
                ver_minor <= minor_q;
                ver_major <= rd_data;
                state     <= ST_IDLE;
              end else begin
                step  <= step_e'(step + 4'd1);
                state <= ST_LAUNCH;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: done never lasts two cycles.
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a failed scan reports zero versions.
  p_err_zero_ver_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (ver_major == '0 && ver_minor == '0));

  // R8: no read leaves the block once a scan has ended.
  p_req_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
    rom_req |-> busy);

  // R9: results hold while idle and no start arrives.
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable({err, ver_major, ver_minor}));

  // R2: the scan position does not move while a byte is awaited.
  p_step_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !rd_done) |=> $stable(step));

endmodule

// File: tb/sim_romhdr_version_reader.sv
module sim_romhdr_version_reader;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned RD_LAT = 3;
  localparam int NVEC = 10;
  // {pointer, bad step (FF = none), minor, major}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h1CFF3412, 32'h40FF00FF, 32'hFFFFA55A, 32'h04FF0102,
    32'h40000000, 32'h40010000, 32'h80030000, 32'h80040000,
    32'h20050000, 32'hFF060000
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy, done, err, rom_req;
  logic [7:0]        ver_major, ver_minor, rom_rdata;
  logic [ADDR_W-1:0] rom_addr;

  always #4 clk = ~clk;

  romhdr_version_reader #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err(err), .ver_major(ver_major), .ver_minor(ver_minor),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  // ROM model: data valid only in the RD_LAT-th cycle after the request.
  logic [7:0]        mem [512];
  logic [RD_LAT-1:0] pv;
  logic [8:0]        pa [RD_LAT];
  always @(posedge clk) begin
    if (rst) pv <= '0;
    else     pv <= {pv[RD_LAT-2:0], rom_req};
    pa[0] <= rom_addr[8:0];
    for (int i = 1; i < RD_LAT; i++) pa[i] <= pa[i-1];
  end
  assign rom_rdata = pv[RD_LAT-1] ? mem[pa[RD_LAT-1]] : 8'hEE;

  int checks = 0;
  int errors = 0;
  int n_req = 0, done_cnt = 0, gap = 0, gap_bad = 0, dbl_done = 0;
  logic prev_done = 1'b0;
  logic [ADDR_W-1:0] seen [16];
  logic cap_err;
  logic [7:0] cap_maj, cap_min;

  always @(negedge clk) begin
    if (rom_req) begin
      if (n_req > 0 && gap < RD_LAT + 1) gap_bad++;
      if (n_req < 16) seen[n_req] = rom_addr;
      n_req++;
      gap = 0;
    end else begin
      gap++;
    end
    if (done) begin
      done_cnt++;
      cap_err = err;
      cap_maj = ver_major;
      cap_min = ver_minor;
    end
    if (done && prev_done) dbl_done++;
    prev_done = done;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_addr(input int k, input int p);
    case (k)
      0: return 0;
      1: return 1;
      2: return 'h18;
      3, 4, 5, 6: return p + k - 3;
      7: return p + 'h12;
      default: return p + 'h13;
    endcase
  endfunction

  task automatic load_rom(input logic [31:0] v);
    int p, bad;
    p = int'(v[31:24]);
    bad = int'(v[23:16]);
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 37 + 11) & 'hFF);
    mem[0] = 8'h55; mem[1] = 8'hAA; mem['h18] = v[31:24];
    mem[p] = 8'h50; mem[p+1] = 8'h43; mem[p+2] = 8'h49; mem[p+3] = 8'h52;
    mem[p+'h12] = v[15:8]; mem[p+'h13] = v[7:0];
    if (bad != 'hFF) mem[exp_addr(bad, p)] = mem[exp_addr(bad, p)] ^ 8'h01;
  endtask

  task automatic run_vec(input logic [31:0] v, input int id, input bit extra_start);
    int p, bad, nexp, amis;
    bit pass;
    string tg;
    p = int'(v[31:24]);
    bad = int'(v[23:16]);
    pass = (bad == 'hFF);
    nexp = pass ? 9 : bad + 1;
    tg = pass ? "R6" : (bad < 2 ? "R3" : "R5");
    load_rom(v);
    @(negedge clk);
    n_req = 0; done_cnt = 0; gap_bad = 0; dbl_done = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 400 && done_cnt == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7", $sformatf("vec%0d done pulses", id), done_cnt + dbl_done, 1);
    chk(tg, $sformatf("vec%0d err", id), int'(cap_err), pass ? 0 : 1);
    chk(pass ? "R6" : "R7", $sformatf("vec%0d major", id), int'(cap_maj), pass ? int'(v[7:0]) : 0);
    chk(pass ? "R6" : "R7", $sformatf("vec%0d minor", id), int'(cap_min), pass ? int'(v[15:8]) : 0);
    chk(pass ? "R9" : "R8", $sformatf("vec%0d read count", id), n_req, nexp);
    amis = 0;
    for (int k = 0; k < nexp && k < 16; k++)
      if (int'(seen[k]) != exp_addr(k, p)) amis++;
    chk("R4", $sformatf("vec%0d address order mismatches", id), amis, 0);
    chk("R2", $sformatf("vec%0d request spacing violations", id), gap_bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: quiet during reset
    chk("R1", "reset busy/done/err/req", int'({busy, done, err, rom_req}), 0);
    chk("R1", "reset versions", int'({ver_major, ver_minor}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset outputs", int'({busy, done, err, rom_req, ver_major, ver_minor}), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i, 1'b0);

    // R9: results and idle port stay put with no start
    run_vec(VEC[0], 100, 1'b0);
    repeat (20) @(negedge clk);
    chk("R9", "held major", int'(ver_major), 'h12);
    chk("R9", "held minor", int'(ver_minor), 'h34);
    chk("R9", "held err", int'(err), 0);
    chk("R8", "no reads while idle", n_req, 9);

    // R9: accepted start clears the results one cycle later
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "start clears outputs", int'({err, ver_major, ver_minor}), 0);
    chk("R9", "busy after start", int'(busy), 1);
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);

    // R9: a start during a scan is ignored
    run_vec(VEC[0], 200, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule